// File: doc/BRIEF.md
# Multiplexed LCD Segment Scanner

This block produces the digital drive codes for a time-multiplexed segment LCD. Every segment pin owns a 6-bit data word with one bit per common phase. A 3-bit mode input selects how many common phases the scan visits (1, 2, 3, 4, 5 or 6) and whether the levels follow a 1/3-bias or a 1/2-bias ladder. On each scan-clock tick the scanner moves to the next common phase. It flips the drive polarity once per frame so that the panel sees no net DC. Each common and segment line gets a 2-bit level code, which an external analog stage turns into a voltage.

Control inputs switch the display on, blank it while the scan keeps running, or hold all LCD segment data at zero. A per-pin map input hands a pin either to the LCD or to general-purpose I/O. In GPIO use, direction and output data come from the low bits of that pin's data word. Some pins can only be inputs and get a pull-up instead. A debug-enable input takes three fixed pins away from both uses. Segment words are loaded through a simple write strobe carrying a pin index.

Top module: `lcd_scan_top`

## Requirements
- R1: While reset is high, and on the first cycles after it, every output is 0, the phase is 0 and all stored segment words read as 0.
- R2: The scan visits phases 0 to N-1 and then returns to 0, one step per cycle with `scan_tick_i` high. N depends on `mode_i`: 000 gives 4, 001 gives 3, 010 gives 2, 011 gives 3, 100 gives 1 (static), 101 gives 5 and 110 gives 6. Mode 111 keeps the phase at 0 and makes all level codes 0.
- R3: Any change of `mode_i` restarts the scan at phase 0 with polarity 0.
- R4: Level codes are 0..3, low to high on the bias ladder. In the 1/3-bias modes (000, 001, 101, 110) with polarity 0, the selected common is 3, the other commons are 1, an on segment is 0 and an off segment is 2. With polarity 1 these become 0, 2, 3 and 1.
- R5: In the 1/2-bias and static modes (010, 011, 100), the selected common is 3 with polarity 0 and 0 with polarity 1. The other commons are always 1. An on segment is the opposite of the selected common, and an off segment equals it.
- R6: The polarity flips each time the scan wraps from phase N-1 to phase 0. In static mode it therefore flips on every tick.
- R7: With `disp_on_i` low, every common and segment code is 0. If `disp_blank_i` is also low the scan is held at phase 0. If `disp_blank_i` is high the scan keeps advancing. With `disp_on_i` high the data is shown, whatever `disp_blank_i` is. Stored data is never changed by these bits.
- R8: While `clr_i` is high, the data words of pins mapped to the LCD are held at 0 and writes to those pins are dropped. Pins mapped to GPIO keep their words and still accept writes.
- R9: A pin with map bit 0 gives segment code 0 and `seg_drive_o` 0. Its `gpio_out_o` is data bit 0, and its `gpio_oe_o` is data bit 1 (1 means output). A pin with map bit 1 has `gpio_oe_o` and `gpio_out_o` at 0.
- R10: Pins marked in `IN_ONLY_MASK` (default pins 5 to 7) never assert `gpio_oe_o`. When their map bit is 0 they assert `pull_en_o`.
- R11: While `dbg_en_i` is high, pins DBG_BASE to DBG_BASE+2 (default 5 to 7) assert `dbg_sel_o`. On those pins, segment code, `seg_drive_o`, `gpio_oe_o`, `gpio_out_o` and `pull_en_o` are all 0, whatever the map bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick_i | input | 1 | One-cycle pulse that advances the scan |
| mode_i | input | 3 | Phase count and bias selection |
| disp_on_i | input | 1 | Display on |
| disp_blank_i | input | 1 | Blank while the scan keeps running |
| clr_i | input | 1 | Level-held clear of LCD segment data |
| map_i | input | NUM_SEG | Per pin: 1 = LCD segment, 0 = GPIO |
| dbg_en_i | input | 1 | Hands the three debug pins to the debug port |
| wr_en_i | input | 1 | Segment word write strobe |
| wr_idx_i | input | IDX_W | Pin index of the write |
| wr_data_i | input | 6 | Segment word to write |
| com_lvl_o | output | 12 | Level code of common j in bits [2j+1:2j] |
| seg_lvl_o | output | 2*NUM_SEG | Level code of segment pin i in bits [2i+1:2i] |
| seg_drive_o | output | NUM_SEG | Pin is driven as an LCD segment |
| gpio_oe_o | output | NUM_SEG | GPIO output enable |
| gpio_out_o | output | NUM_SEG | GPIO output data |
| pull_en_o | output | NUM_SEG | Pull-up enable on input-only pins |
| dbg_sel_o | output | NUM_SEG | Pin is routed to the debug port |
| phase_o | output | 3 | Scan phase that the level codes belong to |
| pol_o | output | 1 | Frame polarity that the level codes belong to |

## Verification
A wrong phase counter or polarity register shows up on `phase_o`, `pol_o` and on all common codes together. This happens two cycles after the tick that causes it, and the error stays visible until the next mode change resets the scan. A corrupted segment word shows up only on that pin's segment code, and only on the phase that selects the bad bit. For that reason, scans sweep every phase of every mode and use data that differs from pin to pin. Mistakes in the map, debug or input-only logic appear on the GPIO and pull-up outputs one cycle after the inputs change.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int DATA_W = 6;
  localparam int LVL_W  = 2;
  localparam int PH_W   = 3;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [2:0]       mode_t;
  typedef logic [PH_W-1:0]  phase_t;

  localparam mode_t MODE_OFF = 3'b111;

  function automatic phase_t phase_count(mode_t m);
    case (m)
      3'b000:  return 3'd4;
      3'b001:  return 3'd3;
      3'b010:  return 3'd2;
      3'b011:  return 3'd3;
      3'b100:  return 3'd1;
      3'b101:  return 3'd5;
      3'b110:  return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic half_bias(mode_t m);
    return (m == 3'b010) || (m == 3'b011) || (m == 3'b100);
  endfunction

  function automatic lvl_t com_code(logic sel, logic pol, logic half);
    if (sel)  return pol ? 2'd0 : 2'd3;
    if (half) return 2'd1;
    return pol ? 2'd2 : 2'd1;
  endfunction

  function automatic lvl_t seg_code(logic on, logic pol, logic half);
    if (on)   return pol ? 2'd3 : 2'd0;
    if (half) return pol ? 2'd0 : 2'd3;
    return pol ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/lcd_seg_store.sv
module lcd_seg_store
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic [NUM_SEG-1:0]        map,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_SEG*DATA_W-1:0] data_flat
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= '0;
      end else if (clr && map[i]) begin
        cell_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        cell_q <= wr_data;
      end
    end
    assign data_flat[i*DATA_W +: DATA_W] = cell_q;
  end
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  mode_t  mode_i,
  input  logic   run_i,
  input  logic   show_i,
  output phase_t phase_q,
  output logic   pol_q,
  output logic   show_q,
  output mode_t  mode_q
);
  phase_t cnt;
  logic   restart;

  always_comb begin
    cnt     = phase_count(mode_i);
    restart = !run_i || (mode_i != mode_q) || (cnt == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      pol_q   <= 1'b0;
      show_q  <= 1'b0;
      mode_q  <= '0;
    end else begin
      mode_q <= mode_i;
      show_q <= show_i && (mode_i != MODE_OFF);
      if (restart) begin
        phase_q <= '0;
        pol_q   <= 1'b0;
      end else if (tick) begin
        if (phase_q >= cnt - 3'd1) begin
          phase_q <= '0;
          pol_q   <= ~pol_q;
        end else begin
          phase_q <= phase_q + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_drive_enc.sv
module lcd_drive_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int NUM_COM = 6
) (
  input  phase_t                    phase,
  input  logic                      pol,
  input  logic                      show,
  input  mode_t                     mode,
  input  logic [NUM_SEG*DATA_W-1:0] data_flat,
  input  logic [NUM_SEG-1:0]        lcd_pin,
  output logic [NUM_COM*LVL_W-1:0]  com_lvl,
  output logic [NUM_SEG*LVL_W-1:0]  seg_lvl
);
  logic half;
  assign half = half_bias(mode);

  for (genvar j = 0; j < NUM_COM; j++) begin : g_com
    assign com_lvl[j*LVL_W +: LVL_W] =
      show ? com_code(phase == PH_W'(j), pol, half) : '0;
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic [DATA_W-1:0] word;
    logic              bit_on;
    assign word   = data_flat[i*DATA_W +: DATA_W];
    assign bit_on = word[phase];
    assign seg_lvl[i*LVL_W +: LVL_W] =
      (show && lcd_pin[i]) ? seg_code(bit_on, pol, half) : '0;
  end
endmodule

// File: rtl/lcd_pin_mux.sv
module lcd_pin_mux #(
  parameter int                 NUM_SEG  = 8,
  parameter logic [NUM_SEG-1:0] IN_ONLY  = '0,
  parameter logic [NUM_SEG-1:0] DBG_MASK = '0
) (
  input  logic [NUM_SEG-1:0]   map,
  input  logic                 dbg_en,
  input  logic [NUM_SEG*2-1:0] io_bits,
  output logic [NUM_SEG-1:0]   lcd_pin,
  output logic [NUM_SEG-1:0]   oe,
  output logic [NUM_SEG-1:0]   dout,
  output logic [NUM_SEG-1:0]   pull,
  output logic [NUM_SEG-1:0]   dbg_sel
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_pin
    logic taken;
    logic as_io;
    assign taken      = dbg_en && DBG_MASK[i];
    assign as_io      = !map[i] && !taken;
    assign lcd_pin[i] = map[i] && !taken;
    assign oe[i]      = as_io && !IN_ONLY[i] && io_bits[2*i+1];
    assign dout[i]    = as_io && io_bits[2*i];
    assign pull[i]    = as_io && IN_ONLY[i];
    assign dbg_sel[i] = taken;
  end
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int                 NUM_SEG      = 8,
  parameter logic [NUM_SEG-1:0] IN_ONLY_MASK = 8'hE0,
  parameter int                 DBG_BASE     = 5,
  localparam int                IDX_W        = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int                NUM_COM      = DATA_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scan_tick_i,
  input  logic [2:0]                 mode_i,
  input  logic                       disp_on_i,
  input  logic                       disp_blank_i,
  input  logic                       clr_i,
  input  logic [NUM_SEG-1:0]         map_i,
  input  logic                       dbg_en_i,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_COM*LVL_W-1:0]   com_lvl_o,
  output logic [NUM_SEG*LVL_W-1:0]   seg_lvl_o,
  output logic [NUM_SEG-1:0]         seg_drive_o,
  output logic [NUM_SEG-1:0]         gpio_oe_o,
  output logic [NUM_SEG-1:0]         gpio_out_o,
  output logic [NUM_SEG-1:0]         pull_en_o,
  output logic [NUM_SEG-1:0]         dbg_sel_o,
  output logic [PH_W-1:0]            phase_o,
  output logic                       pol_o
);
  localparam logic [NUM_SEG-1:0] DBG_MASK = NUM_SEG'(3'b111) << DBG_BASE;

  logic [NUM_SEG*DATA_W-1:0] data_flat;
  logic [NUM_SEG*2-1:0]      io_bits;
  phase_t                    phase_q;
  logic                      pol_q, show_q;
  mode_t                     mode_q;
  logic [NUM_SEG-1:0]        lcd_pin, oe_c, dout_c, pull_c, dbg_c;
  logic [NUM_COM*LVL_W-1:0]  com_c;
  logic [NUM_SEG*LVL_W-1:0]  seg_c;

  lcd_seg_store #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst), .clr(clr_i), .map(map_i), .wr_en(wr_en_i),
    .wr_idx(wr_idx_i), .wr_data(wr_data_i), .data_flat(data_flat)
  );

  lcd_phase_seq seq_i (
    .clk(clk), .rst(rst), .tick(scan_tick_i), .mode_i(mode_i),
    .run_i(disp_on_i || disp_blank_i), .show_i(disp_on_i),
    .phase_q(phase_q), .pol_q(pol_q), .show_q(show_q), .mode_q(mode_q)
  );

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_io
    assign io_bits[2*i +: 2] = data_flat[i*DATA_W +: 2];
  end

  lcd_pin_mux #(.NUM_SEG(NUM_SEG), .IN_ONLY(IN_ONLY_MASK), .DBG_MASK(DBG_MASK)) mux_i (
    .map(map_i), .dbg_en(dbg_en_i), .io_bits(io_bits), .lcd_pin(lcd_pin),
    .oe(oe_c), .dout(dout_c), .pull(pull_c), .dbg_sel(dbg_c)
  );

  lcd_drive_enc #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) enc_i (
    .phase(phase_q), .pol(pol_q), .show(show_q), .mode(mode_q),
    .data_flat(data_flat), .lcd_pin(lcd_pin), .com_lvl(com_c), .seg_lvl(seg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl_o   <= '0;
      seg_lvl_o   <= '0;
      seg_drive_o <= '0;
      gpio_oe_o   <= '0;
      gpio_out_o  <= '0;
      pull_en_o   <= '0;
      dbg_sel_o   <= '0;
      phase_o     <= '0;
      pol_o       <= 1'b0;
    end else begin
      com_lvl_o   <= com_c;
      seg_lvl_o   <= seg_c;
      seg_drive_o <= lcd_pin;
      gpio_oe_o   <= oe_c;
      gpio_out_o  <= dout_c;
      pull_en_o   <= pull_c;
      dbg_sel_o   <= dbg_c;
      phase_o     <= phase_q;
      pol_o       <= pol_q;
    end
  end
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int                 NUM_SEG      = 8,
  parameter logic [NUM_SEG-1:0] IN_ONLY_MASK = 8'hE0,
  parameter int                 DBG_BASE     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           mode_i,
  input logic                 disp_on_i,
  input logic                 dbg_en_i,
  input logic [11:0]          com_lvl_o,
  input logic [NUM_SEG*2-1:0] seg_lvl_o,
  input logic [NUM_SEG-1:0]   seg_drive_o,
  input logic [NUM_SEG-1:0]   gpio_oe_o,
  input logic [NUM_SEG-1:0]   pull_en_o,
  input logic [NUM_SEG-1:0]   dbg_sel_o,
  input logic [2:0]           phase_o,
  input logic                 pol_o
);
  localparam logic [NUM_SEG-1:0] DBG_MASK = NUM_SEG'(3'b111) << DBG_BASE;

  AST_DARK_IS_FLAT: assert property (@(posedge clk) disable iff (rst)
    $past(!disp_on_i || mode_i == 3'b111) |=> (com_lvl_o == '0 && seg_lvl_o == '0)); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_o != $past(phase_o)) |-> (phase_o == 3'd0 || phase_o == $past(phase_o) + 3'd1)); // R2

  AST_POL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pol_o != $past(pol_o)) |-> (phase_o == 3'd0)); // R6

  AST_LCD_NOT_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (seg_drive_o & gpio_oe_o) == '0); // R9

  AST_INONLY_NO_OE: assert property (@(posedge clk) disable iff (rst)
    (gpio_oe_o & IN_ONLY_MASK) == '0); // R10

  AST_DBG_TAKEOVER: assert property (@(posedge clk) disable iff (rst)
    dbg_en_i |=> ((dbg_sel_o & DBG_MASK) == DBG_MASK && (pull_en_o & DBG_MASK) == '0)); // R11

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_quiet
    AST_IO_SEG_QUIET: assert property (@(posedge clk) disable iff (rst)
      !seg_drive_o[i] |-> (seg_lvl_o[2*i +: 2] == 2'd0)); // R9
  end
endmodule

bind lcd_scan_top lcd_scan_chk #(
  .NUM_SEG(NUM_SEG), .IN_ONLY_MASK(IN_ONLY_MASK), .DBG_BASE(DBG_BASE)
) chk_i (.*);

// File: tb/lcd_scan_top_tb_top.sv
module lcd_scan_top_tb_top;
  localparam int         NS    = 8;
  localparam logic [7:0] INO   = 8'hE0;
  localparam logic [7:0] DMASK = 8'hE0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_tick_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        disp_on_i = 1'b0;
  logic        disp_blank_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [7:0]  map_i = 8'h00;
  logic        dbg_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = 3'd0;
  logic [5:0]  wr_data_i = 6'd0;
  logic [11:0] com_lvl_o;
  logic [15:0] seg_lvl_o;
  logic [7:0]  seg_drive_o, gpio_oe_o, gpio_out_o, pull_en_o, dbg_sel_o;
  logic [2:0]  phase_o;
  logic        pol_o;

  lcd_scan_top #(.NUM_SEG(NS), .IN_ONLY_MASK(INO), .DBG_BASE(5)) dut_i (
    .clk(clk), .rst(rst), .scan_tick_i(scan_tick_i), .mode_i(mode_i),
    .disp_on_i(disp_on_i), .disp_blank_i(disp_blank_i), .clr_i(clr_i),
    .map_i(map_i), .dbg_en_i(dbg_en_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .com_lvl_o(com_lvl_o), .seg_lvl_o(seg_lvl_o),
    .seg_drive_o(seg_drive_o), .gpio_oe_o(gpio_oe_o), .gpio_out_o(gpio_out_o),
    .pull_en_o(pull_en_o), .dbg_sel_o(dbg_sel_o), .phase_o(phase_o), .pol_o(pol_o)
  );

  always #5 clk = ~clk;

  logic [5:0] m_data [NS];
  int         m_ph;
  logic       m_pol;
  int         total = 0;
  int         bad = 0;

  function automatic int phases_of(logic [2:0] m);
    case (m)
      3'd0: return 4;  3'd1: return 3;  3'd2: return 2;  3'd3: return 3;
      3'd4: return 1;  3'd5: return 5;  3'd6: return 6;  default: return 0;
    endcase
  endfunction

  function automatic bit lit();
    return disp_on_i && (mode_i != 3'd7);
  endfunction

  function automatic logic [11:0] want_com();
    logic [11:0] r = '0;
    bit half = (mode_i >= 3'd2 && mode_i <= 3'd4);
    if (!lit()) return '0;
    for (int j = 0; j < 6; j++) begin
      if (j == m_ph)  r[j*2 +: 2] = m_pol ? 2'd0 : 2'd3;
      else if (half)  r[j*2 +: 2] = 2'd1;
      else            r[j*2 +: 2] = m_pol ? 2'd2 : 2'd1;
    end
    return r;
  endfunction

  function automatic logic [15:0] want_seg();
    logic [15:0] r = '0;
    bit half = (mode_i >= 3'd2 && mode_i <= 3'd4);
    for (int i = 0; i < NS; i++) begin
      bit lcd = map_i[i] && !(dbg_en_i && DMASK[i]);
      bit on  = m_data[i][m_ph];
      if (lit() && lcd) begin
        if (on)        r[i*2 +: 2] = m_pol ? 2'd3 : 2'd0;
        else if (half) r[i*2 +: 2] = m_pol ? 2'd0 : 2'd3;
        else           r[i*2 +: 2] = m_pol ? 2'd1 : 2'd2;
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic settle_check(string tag);
    logic [7:0] dp, io, oe, dout, pl;
    repeat (2) @(negedge clk);
    dp   = dbg_en_i ? DMASK : 8'h00;
    io   = ~map_i & ~dp;
    oe   = '0;
    dout = '0;
    for (int i = 0; i < NS; i++) begin
      oe[i]   = io[i] && !INO[i] && m_data[i][1];
      dout[i] = io[i] && m_data[i][0];
    end
    pl = io & INO;
    chk(tag, "phase", 32'(phase_o), 32'(m_ph));
    chk(tag, "pol", 32'(pol_o), 32'(m_pol));
    chk(tag, "com", 32'(com_lvl_o), 32'(want_com()));
    chk(tag, "seg", 32'(seg_lvl_o), 32'(want_seg()));
    chk(tag, "drive", 32'(seg_drive_o), 32'(map_i & ~dp));
    chk(tag, "oe", 32'(gpio_oe_o), 32'(oe));
    chk(tag, "out", 32'(gpio_out_o), 32'(dout));
    chk(tag, "pull", 32'(pull_en_o), 32'(pl));
    chk(tag, "dbg", 32'(dbg_sel_o), 32'(dp));
  endtask

  task automatic apply_cfg(logic [2:0] m, logic on, logic bl, logic [7:0] mp, logic dg);
    @(negedge clk);
    if (m != mode_i || !(on || bl) || m == 3'd7) begin
      m_ph  = 0;
      m_pol = 1'b0;
    end
    mode_i = m; disp_on_i = on; disp_blank_i = bl; map_i = mp; dbg_en_i = dg;
  endtask

  task automatic tick();
    @(negedge clk);
    scan_tick_i = 1'b1;
    if ((disp_on_i || disp_blank_i) && mode_i != 3'd7) begin
      if (m_ph >= phases_of(mode_i) - 1) begin
        m_ph  = 0;
        m_pol = ~m_pol;
      end else begin
        m_ph++;
      end
    end
    @(negedge clk);
    scan_tick_i = 1'b0;
  endtask

  task automatic wr(int idx, logic [5:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_data_i = d;
    if (!(clr_i && map_i[idx])) m_data[idx] = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_clr(logic v);
    @(negedge clk);
    clr_i = v;
    if (v) for (int i = 0; i < NS; i++) if (map_i[i]) m_data[i] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) m_data[i] = '0;
    m_ph = 0; m_pol = 1'b0;

    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    chk("R1", "com in reset", 32'(com_lvl_o), 32'h0);
    chk("R1", "pull in reset", 32'(pull_en_o), 32'h0);
    chk("R1", "phase in reset", 32'(phase_o), 32'h0);
    rst = 1'b0;
    settle_check("R1");

    // R4 R6: 4-phase 1/3 bias, distinct data per pin, two full frames
    apply_cfg(3'd0, 1'b1, 1'b0, 8'hFF, 1'b0);
    for (int i = 0; i < NS; i++) wr(i, 6'(6'h15 ^ (i * 7)));
    settle_check("R4");
    for (int k = 0; k < 9; k++) begin
      tick();
      settle_check("R4 R6");
    end

    // R2: every valid mode through more than one frame
    for (int m = 0; m < 7; m++) begin
      apply_cfg(3'(m), 1'b1, 1'b0, 8'hFF, 1'b0);
      settle_check("R2");
      for (int k = 0; k < phases_of(3'(m)) + 2; k++) begin
        tick();
        settle_check((m >= 2 && m <= 4) ? "R2 R5" : "R2");
      end
    end

    // R2: reserved mode stays at phase 0, flat
    apply_cfg(3'd7, 1'b1, 1'b0, 8'hFF, 1'b0);
    tick(); tick();
    settle_check("R2 reserved");

    // R3: mode change in the middle of a frame restarts the scan
    apply_cfg(3'd6, 1'b1, 1'b0, 8'hFF, 1'b0);
    tick(); tick(); tick();
    settle_check("R3 pre");
    apply_cfg(3'd5, 1'b1, 1'b0, 8'hFF, 1'b0);
    settle_check("R3");
    apply_cfg(3'd4, 1'b1, 1'b0, 8'hFF, 1'b0);
    tick();
    apply_cfg(3'd0, 1'b1, 1'b0, 8'hFF, 1'b0);
    settle_check("R3 pol");

    // R7: blank keeps scanning but drives flat; off holds phase 0
    tick(); tick();
    apply_cfg(3'd0, 1'b0, 1'b1, 8'hFF, 1'b0);
    tick();
    settle_check("R7 blank");
    apply_cfg(3'd0, 1'b1, 1'b1, 8'hFF, 1'b0);
    settle_check("R7 both");
    apply_cfg(3'd0, 1'b0, 1'b0, 8'hFF, 1'b0);
    tick();
    settle_check("R7 off");
    apply_cfg(3'd0, 1'b1, 1'b0, 8'hFF, 1'b0);
    tick();
    settle_check("R7 data kept");

    // R8: clear is level-held, LCD pins only
    apply_cfg(3'd0, 1'b1, 1'b0, 8'h0F, 1'b0);
    for (int i = 0; i < NS; i++) wr(i, 6'h3F);
    settle_check("R8 pre");
    set_clr(1'b1);
    wr(1, 6'h2A);
    wr(4, 6'h01);
    settle_check("R8 held");
    set_clr(1'b0);
    settle_check("R8 after");
    tick();
    settle_check("R8 tick");

    // R9: GPIO direction and data from bits 1 and 0
    apply_cfg(3'd0, 1'b1, 1'b0, 8'h00, 1'b0);
    wr(0, 6'h03); wr(1, 6'h3D); wr(2, 6'h02); wr(3, 6'h3C);
    settle_check("R9");

    // R10: input-only pins never drive, pull-up when unmapped
    wr(5, 6'h03); wr(6, 6'h02); wr(7, 6'h01);
    settle_check("R10");
    apply_cfg(3'd0, 1'b1, 1'b0, 8'hFF, 1'b0);
    settle_check("R10 mapped");

    // R11: debug takeover of pins 5..7
    apply_cfg(3'd0, 1'b1, 1'b0, 8'hFF, 1'b1);
    settle_check("R11 mapped");
    apply_cfg(3'd0, 1'b1, 1'b0, 8'h00, 1'b1);
    settle_check("R11 io");

    // Random mix
    for (int it = 0; it < 250; it++) begin
      logic [2:0] m;
      int nw, nt;
      m  = ($urandom % 16 == 0) ? 3'd7 : 3'($urandom % 7);
      apply_cfg(m, ($urandom % 4) != 0, 1'($urandom), 8'($urandom), ($urandom % 4) == 0);
      nw = $urandom % 3;
      for (int w = 0; w < nw; w++) wr($urandom % NS, 6'($urandom));
      nt = $urandom % 8;
      for (int t = 0; t < nt; t++) tick();
      settle_check("RND R2 R4 R5 R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule